// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is one periodic timer channel on a small synchronous register bus. A 32-bit count decrements once on every prescaled tick of the input clock. The prescaler divides by four times a power of four, chosen by a 3-bit code. When a tick arrives while the count already holds zero, the count is reloaded from a reload register rather than wrapping to all ones. In the same cycle a sticky underflow flag is set. Software can route that flag to a level interrupt.

Software typically stops the channel and picks a prescaler code. It then writes the same interval into both the count and reload registers, so that the first period matches every later one, and sets the run bit. The interrupt handler clears the flag by read-modify-write, writing the flag bit as zero. A reader that finds the count larger than on its previous read can inspect the flag to learn that the count wrapped in between.

Top module: `dctmr_channel`

## Requirements
- R1: After reset the count and reload registers read 0xFFFFFFFF, the run and control registers read 0, and `irq` is 0.
- R2: Bit 0 of the run register (offset 0x0) starts the channel. While this bit is 0 the count never changes except through a software write, and the prescaler is held at zero.
- R3: The divide ratio is 4 << (2 × code), where code is control bits [2:0]: /4, /16, /64 and /256 for codes 0 to 3. The first decrement lands exactly one full ratio of cycles after the edge that sets the run bit, and no earlier.
- R4: A tick that finds the count at 0 loads the reload register (offset 0x8), not 0xFFFFFFFF. In the same clock edge it sets the underflow flag, control bit 8.
- R5: The underflow flag stays set until a control write with byte lane 1 enabled carries bit 8 as 0. Writing 1 to bit 8 never sets it. If a clear and a hardware set fall in the same cycle, the flag ends up set.
- R6: `irq` is high exactly while the underflow flag and the interrupt enable (control bit 5) are both 1. Control value 0x20 therefore selects /4 with the interrupt on, and 0x00 selects /4 with it off.
- R7: A software write to the count register (offset 0xC) overrides a decrement or reload in the same cycle. Each byte-enable bit i replaces count bits [8i+7:8i] and leaves the other bytes alone.
- R8: Register offsets are 0x0 (run), 0x4 (control), 0x8 (reload) and 0xC (count). An access with address bits [1:0] not zero is ignored. Read data appears on `bus_rdata` the cycle after the read request. Bits of the run and control registers with no function read as 0.
- R9: A count of 0xFFFFFFFF is a legal value and decrements to 0xFFFFFFFE on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| irq | output | 1 | Level interrupt: underflow flag AND enable |

## Verification
Register writes take effect at the clock edge that samples them. `irq` follows the flag and enable at that same edge with no extra stage. Read data lags the request by exactly one edge and shows the state from before that edge. A tick decrements the count on the edge where the prescaler reaches its last phase, one ratio of cycles after the run bit rises.

The bench drives all inputs on falling edges. A behavioural model updates on each rising edge from the same inputs, and outputs are compared on the following falling edge. Each read is checked against the model state captured when the request was issued. The cases where a write and a tick coincide are timed from the model's own tick prediction, so both land on one edge.

// File: rtl/dctmr_pkg.sv
package dctmr_pkg;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 32;
    localparam int SEL_W    = 3;
    localparam int ADDR_W   = 4;
    localparam int BE_W     = DATA_W / 8;
    // widest prescaler phase counter: largest ratio minus one
    localparam int PSC_W    = 2 + 2 * ((1 << SEL_W) - 1);
    localparam int IE_BIT   = 5;
    localparam int UF_BIT   = 8;

    typedef enum logic [1:0] {
        REG_RUN   = 2'd0,
        REG_CTRL  = 2'd1,
        REG_CONST = 2'd2,
        REG_COUNT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              run;
        logic [SEL_W-1:0]  psel;
        logic              ie;
        logic              uf;
        logic [CNT_W-1:0]  cst;
        logic [DATA_W-1:0] rdata;
    } chan_state_t;
endpackage

// File: rtl/dctmr_prescaler.sv
module dctmr_prescaler #(
    parameter int SEL_W = 3,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PSC_W-1:0] psc_d, psc_q;
    logic [PSC_W:0]   ratio;
    logic [PSC_W:0]   last;

    always_comb begin
        ratio = (PSC_W + 1)'(4) << {sel, 1'b0};
        last  = ratio - 1'b1;
        tick  = run && (psc_q >= last[PSC_W-1:0]);
        if (!run || tick) begin
            psc_d = '0;
        end else begin
            psc_d = psc_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q <= '0;
        end else begin
            psc_q <= psc_d;
        end
    end
endmodule

// File: rtl/dctmr_counter.sv
module dctmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               wr_en,
    input  logic [CNT_W/8-1:0] be,
    input  logic [CNT_W-1:0]   wdata,
    input  logic [CNT_W-1:0]   reload,
    output logic [CNT_W-1:0]   cnt_q,
    output logic               wrap
);
    localparam int LANES = CNT_W / 8;

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        if (wr_en) begin
            for (int b = 0; b < LANES; b++) begin
                if (be[b]) begin
                    cnt_d[8*b +: 8] = wdata[8*b +: 8];
                end
            end
        end else if (tick) begin
            if (cnt_q == '0) begin
                cnt_d = reload;
                wrap  = 1'b1;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/dctmr_channel.sv
module dctmr_channel
    import dctmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    chan_state_t      state_d, state_q;
    reg_sel_e         idx;
    logic             aligned, wr_hit, rd_hit, cnt_wr;
    logic             tick, wrap;
    logic             run_q, uf_q;
    logic [CNT_W-1:0] cnt_q, cst_q;
    logic [DATA_W-1:0] ctrl_view;

    assign run_q = state_q.run;
    assign uf_q  = state_q.uf;
    assign cst_q = state_q.cst;

    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        idx     = reg_sel_e'(bus_addr[3:2]);
        wr_hit  = bus_sel && bus_we && aligned;
        rd_hit  = bus_sel && !bus_we && aligned;
        cnt_wr  = wr_hit && (idx == REG_COUNT);
    end

    dctmr_prescaler #(.SEL_W(SEL_W), .PSC_W(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q.run),
        .sel   (state_q.psel),
        .tick  (tick)
    );

    dctmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .wr_en  (cnt_wr),
        .be     (bus_be),
        .wdata  (bus_wdata),
        .reload (state_q.cst),
        .cnt_q  (cnt_q),
        .wrap   (wrap)
    );

    always_comb begin
        ctrl_view                = '0;
        ctrl_view[SEL_W-1:0]     = state_q.psel;
        ctrl_view[IE_BIT]        = state_q.ie;
        ctrl_view[UF_BIT]        = state_q.uf;
    end

    always_comb begin
        state_d = state_q;
        if (wr_hit) begin
            case (idx)
                REG_RUN: begin
                    if (bus_be[0]) state_d.run = bus_wdata[0];
                end
                REG_CTRL: begin
                    if (bus_be[0]) begin
                        state_d.psel = bus_wdata[SEL_W-1:0];
                        state_d.ie   = bus_wdata[IE_BIT];
                    end
                    if (bus_be[UF_BIT/8] && !bus_wdata[UF_BIT]) state_d.uf = 1'b0;
                end
                REG_CONST: begin
                    for (int b = 0; b < BE_W; b++) begin
                        if (bus_be[b]) state_d.cst[8*b +: 8] = bus_wdata[8*b +: 8];
                    end
                end
                default: ;
            endcase
        end
        // hardware set overrides a same-cycle software clear
        if (wrap) state_d.uf = 1'b1;
        if (rd_hit) begin
            case (idx)
                REG_RUN:   state_d.rdata = {{(DATA_W-1){1'b0}}, state_q.run};
                REG_CTRL:  state_d.rdata = ctrl_view;
                REG_CONST: state_d.rdata = state_q.cst;
                default:   state_d.rdata = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.cst   <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata = state_q.rdata;
    assign irq       = state_q.uf & state_q.ie;
endmodule

// File: rtl/dctmr_channel_chk.sv
module dctmr_channel_chk
    import dctmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BE_W-1:0]   bus_be,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              tick,
    input logic              run_q,
    input logic              uf_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  cst_q
);
    logic wr_ok, cw, uf_clr, hw_set;
    assign wr_ok  = bus_sel && bus_we && (bus_addr[1:0] == 2'b00);
    assign cw     = wr_ok && (bus_addr[3:2] == 2'd3) && (|bus_be);
    assign uf_clr = wr_ok && (bus_addr[3:2] == 2'd1) && bus_be[1] && !bus_wdata[UF_BIT];
    assign hw_set = tick && (cnt_q == '0) && !cw;

    a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !cw) |=> $stable(cnt_q));

    a_r3_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run_q);

    a_r9_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q != '0 && !cw) |=> (cnt_q == $past(cnt_q) - 1'b1));

    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> ((cnt_q == $past(cst_q)) && uf_q));

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_q && !uf_clr) |=> uf_q);

    a_r5_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!uf_q && !hw_set) |=> !uf_q);

    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cw && (&bus_be)) |=> (cnt_q == $past(bus_wdata)));
endmodule

bind dctmr_channel dctmr_channel_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .tick      (tick),
    .run_q     (run_q),
    .uf_q      (uf_q),
    .cnt_q     (cnt_q),
    .cst_q     (cst_q)
);

// File: tb/dctmr_channel_tb.sv
module dctmr_channel_tb_top;
    localparam time CYC = 8ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, we = 1'b0;
    logic [3:0]  addr = '0, be = '0;
    logic [31:0] wd = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit          m_run, m_ie, m_uf;
    int          m_psel, m_phase;
    logic [31:0] m_cnt, m_const;

    always #(CYC/2) clk = ~clk;

    dctmr_channel dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
        .bus_be(be), .bus_wdata(wd), .bus_rdata(rdata), .irq(irq)
    );

    function automatic int ratio(int code);
        return 4 << (2 * code);
    endfunction

    function automatic logic [31:0] mread(logic [3:0] a);
        case (a[3:2])
            2'd0: return {31'b0, m_run};
            2'd1: return {23'b0, m_uf, 2'b0, m_ie, 2'b0, m_psel[2:0]};
            2'd2: return m_const;
            default: return m_cnt;
        endcase
    endfunction

    function automatic bit tick_next();
        return m_run && (m_phase + 1 == ratio(m_psel));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_ie = 0; m_uf = 0; m_psel = 0; m_phase = 0;
            m_cnt = 32'hFFFF_FFFF; m_const = 32'hFFFF_FFFF;
        end else begin
            automatic bit tk = tick_next();
            automatic bit ev = 0;
            automatic bit hit = sel && we && (addr[1:0] == 2'b00);
            automatic logic [31:0] nc = m_cnt;
            m_phase = (!m_run || tk) ? 0 : m_phase + 1;
            if (hit && addr[3:2] == 2'd3) begin
                for (int i = 0; i < 4; i++) if (be[i]) nc[8*i +: 8] = wd[8*i +: 8];
            end else if (tk) begin
                if (m_cnt == 0) begin nc = m_const; ev = 1; end
                else nc = m_cnt - 1;
            end
            m_cnt = nc;
            if (hit && addr[3:2] == 2'd0 && be[0]) m_run = wd[0];
            if (hit && addr[3:2] == 2'd1) begin
                if (be[0]) begin m_psel = int'(wd[2:0]); m_ie = wd[5]; end
                if (be[1] && !wd[8]) m_uf = 0;
            end
            if (hit && addr[3:2] == 2'd2)
                for (int i = 0; i < 4; i++) if (be[i]) m_const[8*i +: 8] = wd[8*i +: 8];
            if (ev) m_uf = 1;
        end
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // interrupt level compared with the model on every cycle
    always @(negedge clk) begin
        if (rst_n && !done) chk(irq === (m_uf && m_ie), "R6", {31'b0, irq}, {31'b0, m_uf && m_ie});
    end

    // called at a falling edge; returns at the next falling edge
    task automatic wr(logic [3:0] a, logic [3:0] b, logic [31:0] d);
        sel = 1; we = 1; addr = a; be = b; wd = d;
        @(negedge clk);
        sel = 0; we = 0; be = '0;
    endtask

    task automatic rd(logic [3:0] a, string req, output logic [31:0] got);
        automatic logic [31:0] exp;
        sel = 1; we = 0; addr = a;
        exp = mread(a);
        @(negedge clk);
        sel = 0;
        got = rdata;
        chk(got === exp, req, got, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CYC * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        idle(3);
        rst_n = 1;
        idle(1);

        // R1 reset state
        chk(irq === 1'b0, "R1", {31'b0, irq}, 32'h0);
        rd(4'h0, "R1", v); chk(v === 32'h0, "R1", v, 32'h0);
        rd(4'h4, "R1", v); chk(v === 32'h0, "R1", v, 32'h0);
        rd(4'h8, "R1", v); chk(v === 32'hFFFF_FFFF, "R1", v, 32'hFFFF_FFFF);
        rd(4'hC, "R8", v); chk(v === 32'hFFFF_FFFF, "R1", v, 32'hFFFF_FFFF);

        // R2 stopped channel stays frozen
        idle(20);
        rd(4'hC, "R2", v); chk(v === 32'hFFFF_FFFF, "R2", v, 32'hFFFF_FFFF);

        // R3 first decrement timing, R9 full-scale start
        wr(4'h0, 4'h1, 32'h1);
        idle(3);
        rd(4'hC, "R3", v); chk(v === 32'hFFFF_FFFF, "R3", v, 32'hFFFF_FFFF);
        rd(4'hC, "R9", v); chk(v === 32'hFFFF_FFFE, "R9", v, 32'hFFFF_FFFE);

        // R3 ratio sweep
        for (int s = 0; s < 4; s++) begin
            wr(4'h0, 4'h1, 32'h0);
            wr(4'hC, 4'hF, 32'd1000);
            wr(4'h4, 4'h3, s);
            wr(4'h0, 4'h1, 32'h1);
            idle(ratio(s) * 3 + 1);
            rd(4'hC, "R3", v);
            chk(v === 32'd997, "R3", v, 32'd997);
        end

        // R2 stop freezes mid-run
        wr(4'h0, 4'h1, 32'h0);
        rd(4'hC, "R2", v);
        idle(30);
        rd(4'hC, "R2", v2); chk(v2 === v, "R2", v2, v);

        // R4 reload from constant and flag, R6 interrupt with 0x20
        wr(4'h8, 4'hF, 32'd5);
        wr(4'hC, 4'hF, 32'd2);
        wr(4'h4, 4'h3, 32'h20);
        wr(4'h0, 4'h1, 32'h1);
        idle(14);
        rd(4'h4, "R4", v); chk(v === 32'h120, "R4", v, 32'h120);
        chk(irq === 1'b1, "R6", {31'b0, irq}, 32'h1);
        rd(4'hC, "R4", v);

        // R5 clear by zero, write-one ignored
        wr(4'h0, 4'h1, 32'h0);
        wr(4'h4, 4'h3, 32'h20);
        rd(4'h4, "R5", v); chk(v === 32'h20, "R5", v, 32'h20);
        wr(4'h4, 4'h3, 32'h120);
        rd(4'h4, "R5", v); chk(v === 32'h20, "R5", v, 32'h20);
        chk(irq === 1'b0, "R5", {31'b0, irq}, 32'h0);

        // R6 flag without enable keeps irq low; enabling raises it
        wr(4'h4, 4'h3, 32'h0);
        wr(4'hC, 4'hF, 32'd0);
        wr(4'h0, 4'h1, 32'h1);
        idle(6);
        chk(irq === 1'b0, "R6", {31'b0, irq}, 32'h0);
        wr(4'h0, 4'h1, 32'h0);
        rd(4'h4, "R6", v); chk(v === 32'h100, "R6", v, 32'h100);
        wr(4'h4, 4'h1, 32'h20);
        chk(irq === 1'b1, "R6", {31'b0, irq}, 32'h1);

        // R5 set wins over a same-cycle clear
        wr(4'h8, 4'hF, 32'd3);
        wr(4'hC, 4'hF, 32'd1);
        wr(4'h4, 4'h3, 32'h20);
        wr(4'h0, 4'h1, 32'h1);
        while (!(tick_next() && m_cnt == 0)) @(negedge clk);
        wr(4'h4, 4'h3, 32'h20);
        rd(4'h4, "R5", v); chk(v === 32'h120, "R5", v, 32'h120);

        // R7 software write beats a same-cycle tick
        while (!tick_next()) @(negedge clk);
        wr(4'hC, 4'hF, 32'h1234);
        rd(4'hC, "R7", v); chk(v === 32'h1234, "R7", v, 32'h1234);

        // R7 single byte lane merge
        wr(4'h0, 4'h1, 32'h0);
        rd(4'hC, "R7", v);
        wr(4'hC, 4'h2, 32'h0000_CD00);
        rd(4'hC, "R7", v2);
        chk(v2 === {v[31:16], 8'hCD, v[7:0]}, "R7", v2, {v[31:16], 8'hCD, v[7:0]});

        // R8 unused bits, misaligned access ignored
        wr(4'h4, 4'hF, 32'hFFFF_FFFF);
        rd(4'h4, "R8", v); chk((v & ~32'h100) === 32'h27, "R8", v, 32'h27);
        wr(4'h9, 4'hF, 32'hAAAA_5555);
        rd(4'h8, "R8", v); chk(v === 32'd3, "R8", v, 32'd3);
        wr(4'h0, 4'hF, 32'hFFFF_FFFF);
        rd(4'h0, "R8", v); chk(v === 32'h1, "R8", v, 32'h1);
        idle(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule